// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words for a dual synthesizer (an IF channel and an RF channel) from a three-wire serial port. The port has a data line, a serial clock and a load strobe. Bits arrive most significant first and collect in a 23-bit shift register. When the load strobe rises, the register is copied into one of four holding latches. The two lowest bits of the word pick the latch: the IF reference-divider setting, the RF reference-divider setting, the IF main-divider setting or the RF main-divider setting. Each of the two kinds of latch has its own field layout.

All three serial lines are brought into the system clock domain through two-flop synchronisers. Edges are found there by comparing each synchronised line with its previous value. The block also drives a shared monitor pin. That pin shows either the lock indication or one of four divider taps, chosen by fields held in the latches. The counters that use the settings are outside this block.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each rising edge of `serClk` seen while `serLoad` is low shifts one `serData` bit into the shift register, most significant bit first. After 23 such edges, bit position k (1 to 23, position 1 least significant and sent last) holds the bit sent in place 24−k.
- R2: A rising edge of `serLoad` copies the register into exactly one latch, chosen by the value 2·(position 2) + (position 1): 0 is the IF reference latch, 1 the RF reference latch, 2 the IF main latch and 3 the RF main latch. The other three latches keep their contents. The copied values appear at the outputs on the third system clock rising edge after `serLoad` is driven high.
- R3: In a reference word, position 3 is monitor select bit 0, position 4 is monitor select bit 1, positions 5..18 are the divide ratio (position 5 least significant) and position 19 is the pump-current select (1 = high). Positions 20..23 are ignored. Only the IF reference latch's monitor select bits are used.
- R4: In a main-divider word, position 3 is the monitor-enable bit, positions 4..10 are the swallow count (position 4 least significant), positions 11..21 are the program count (position 11 least significant), position 22 is the prescaler select and position 23 is the phase polarity.
- R5: Rising edges of `serClk` while `serLoad` is high do not change the shift register, so a later load with no new bits between copies the same word again.
- R6: A reference word whose divide ratio is below 3 is discarded, and the addressed reference latch keeps its previous value.
- R7: While the monitor-enable bit in effect is 0, `monOut` equals `lockIn`.
- R8: While the monitor-enable bit in effect is 1, `monOut` follows a tap chosen by the IF reference monitor select value s = 2·bit1 + bit0: 0 picks `ifRefTap`, 1 `rfRefTap`, 2 `ifCmpTap`, 3 `rfCmpTap`.
- R9: The monitor-enable bit in effect is the one from the most recent load into either main latch, IF or RF.
- R10: After reset, all latch outputs are zero and the monitor-enable bit in effect is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock |
| serData | input | 1 | Serial data |
| serLoad | input | 1 | Load strobe |
| lockIn | input | 1 | Lock indication to monitor |
| ifRefTap | input | 1 | IF reference divider tap |
| rfRefTap | input | 1 | RF reference divider tap |
| ifCmpTap | input | 1 | IF comparison divider tap |
| rfCmpTap | input | 1 | RF comparison divider tap |
| ifRefRatio | output | 14 | IF reference divide ratio |
| ifRefPumpHi | output | 1 | IF pump-current select |
| rfRefRatio | output | 14 | RF reference divide ratio |
| rfRefPumpHi | output | 1 | RF pump-current select |
| ifSwallow | output | 7 | IF swallow count |
| ifProg | output | 11 | IF program count |
| ifPrescSel | output | 1 | IF prescaler select |
| ifPhasePol | output | 1 | IF phase polarity |
| rfSwallow | output | 7 | RF swallow count |
| rfProg | output | 11 | RF program count |
| rfPrescSel | output | 1 | RF prescaler select |
| rfPhasePol | output | 1 | RF phase polarity |
| monOut | output | 1 | Shared monitor pin |

## Verification
A serial edge goes through two synchroniser flops and one edge-detect compare. A latch therefore changes on the third rising edge of the system clock after the load strobe is driven high. The scoreboard monitor compares the latches four falling edges after the expected word is queued, which is after that change and long before the strobe is released. The monitor pin is combinational from the latches and taps. Its checks drive the taps on a falling edge and sample one nanosecond later, away from any rising edge.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int WORD_W   = 23;
  localparam int REF_W    = 14;
  localparam int SWAL_W   = 7;
  localparam int PROG_W   = 11;
  localparam int MIN_REF  = 3;
  // field positions (0-based register index = bit position - 1)
  localparam int SEL0_POS = 2;
  localparam int SEL1_POS = 3;
  localparam int REF_LSB  = 4;
  localparam int PUMP_POS = REF_LSB + REF_W;
  localparam int MEN_POS  = 2;
  localparam int SWAL_LSB = 3;
  localparam int PROG_LSB = SWAL_LSB + SWAL_W;
  localparam int PRE_POS  = PROG_LSB + PROG_W;
  localparam int POL_POS  = PRE_POS + 1;

  typedef struct packed {
    logic shift;
    logic bitVal;
    logic load;
    logic loadHigh;
  } strobe_t;

  typedef struct packed {
    logic             sel1;
    logic             sel0;
    logic [REF_W-1:0] ratio;
    logic             pumpHi;
  } ref_t;

  typedef struct packed {
    logic              monEn;
    logic [SWAL_W-1:0] swallow;
    logic [PROG_W-1:0] prog;
    logic              presc;
    logic              phasePol;
  } main_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= din;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serLoad,
  output strobe_t strb
);
  logic [2:0] syncOut;
  logic clkLvl, dataLvl, loadLvl;
  logic clkPrev, loadPrev;

  cfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({serLoad, serData, serClk}),
    .dout (syncOut)
  );

  assign {loadLvl, dataLvl, clkLvl} = syncOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= clkLvl;
      loadPrev <= loadLvl;
    end
  end

  always_comb begin
    strb.shift    = clkLvl & ~clkPrev & ~loadLvl;
    strb.bitVal   = dataLvl;
    strb.load     = loadLvl & ~loadPrev;
    strb.loadHigh = loadLvl;
  end
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import serial_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         strb,
  input  logic            lockIn,
  input  logic [3:0]      taps,
  output ref_t  [1:0]     refOut,
  output main_t [1:0]     mainOut,
  output logic            monOut
);
  logic [WORD_W-1:0] shiftReg;
  logic [1:0]        target;
  ref_t              refWord;
  main_t             mainWord;
  logic              refOk;
  logic              monEnQ;
  ref_t  [1:0]       refQ;
  main_t [1:0]       mainQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[WORD_W-2:0], strb.bitVal};
  end

  always_comb begin
    target           = shiftReg[1:0];
    refWord.sel0     = shiftReg[SEL0_POS];
    refWord.sel1     = shiftReg[SEL1_POS];
    refWord.ratio    = shiftReg[REF_LSB +: REF_W];
    refWord.pumpHi   = shiftReg[PUMP_POS];
    mainWord.monEn   = shiftReg[MEN_POS];
    mainWord.swallow = shiftReg[SWAL_LSB +: SWAL_W];
    mainWord.prog    = shiftReg[PROG_LSB +: PROG_W];
    mainWord.presc   = shiftReg[PRE_POS];
    mainWord.phasePol= shiftReg[POL_POS];
    refOk            = (refWord.ratio >= REF_W'(MIN_REF));
  end

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      localparam logic [1:0] REF_CODE  = 2'(ch);
      localparam logic [1:0] MAIN_CODE = 2'(ch + 2);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) refQ[ch] <= '0;
        else if (strb.load && target == REF_CODE && refOk) refQ[ch] <= refWord;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mainQ[ch] <= '0;
        else if (strb.load && target == MAIN_CODE) mainQ[ch] <= mainWord;
      end

      assert_ref_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && target == REF_CODE && refOk) |=> refQ[ch] == $past(refWord));

      assert_ref_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && target == REF_CODE && !refOk) |=> $stable(refQ[ch]));

      assert_main_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && target == MAIN_CODE) |=> mainQ[ch] == $past(mainWord));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) monEnQ <= 1'b0;
    else if (strb.load && target[1]) monEnQ <= mainWord.monEn;
  end

  assign monOut  = monEnQ ? taps[{refQ[0].sel1, refQ[0].sel0}] : lockIn;
  assign refOut  = refQ;
  assign mainOut = mainQ;

  assert_hold_while_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadHigh |=> $stable(shiftReg));

  assert_men_follows_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && target[1]) |=> monEnQ == $past(shiftReg[MEN_POS]));

  assert_men_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.load && target[1]) |=> $stable(monEnQ));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  input  logic              lockIn,
  input  logic              ifRefTap,
  input  logic              rfRefTap,
  input  logic              ifCmpTap,
  input  logic              rfCmpTap,
  output logic [REF_W-1:0]  ifRefRatio,
  output logic              ifRefPumpHi,
  output logic [REF_W-1:0]  rfRefRatio,
  output logic              rfRefPumpHi,
  output logic [SWAL_W-1:0] ifSwallow,
  output logic [PROG_W-1:0] ifProg,
  output logic              ifPrescSel,
  output logic              ifPhasePol,
  output logic [SWAL_W-1:0] rfSwallow,
  output logic [PROG_W-1:0] rfProg,
  output logic              rfPrescSel,
  output logic              rfPhasePol,
  output logic              monOut
);
  strobe_t      strb;
  ref_t  [1:0]  refOut;
  main_t [1:0]  mainOut;

  cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .strb   (strb)
  );

  cfg_datapath u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .lockIn (lockIn),
    .taps   ({rfCmpTap, ifCmpTap, rfRefTap, ifRefTap}),
    .refOut (refOut),
    .mainOut(mainOut),
    .monOut (monOut)
  );

  assign ifRefRatio  = refOut[0].ratio;
  assign ifRefPumpHi = refOut[0].pumpHi;
  assign rfRefRatio  = refOut[1].ratio;
  assign rfRefPumpHi = refOut[1].pumpHi;
  assign ifSwallow   = mainOut[0].swallow;
  assign ifProg      = mainOut[0].prog;
  assign ifPrescSel  = mainOut[0].presc;
  assign ifPhasePol  = mainOut[0].phasePol;
  assign rfSwallow   = mainOut[1].swallow;
  assign rfProg      = mainOut[1].prog;
  assign rfPrescSel  = mainOut[1].presc;
  assign rfPhasePol  = mainOut[1].phasePol;
endmodule

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic lockIn = 1'b0;
  logic [3:0] taps = 4'b0;
  logic [13:0] ifRefRatio, rfRefRatio;
  logic ifRefPumpHi, rfRefPumpHi;
  logic [6:0] ifSwallow, rfSwallow;
  logic [10:0] ifProg, rfProg;
  logic ifPrescSel, ifPhasePol, rfPrescSel, rfPhasePol, monOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_cfg_loader uut (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .lockIn(lockIn), .ifRefTap(taps[0]), .rfRefTap(taps[1]), .ifCmpTap(taps[2]), .rfCmpTap(taps[3]),
    .ifRefRatio(ifRefRatio), .ifRefPumpHi(ifRefPumpHi), .rfRefRatio(rfRefRatio), .rfRefPumpHi(rfRefPumpHi),
    .ifSwallow(ifSwallow), .ifProg(ifProg), .ifPrescSel(ifPrescSel), .ifPhasePol(ifPhasePol),
    .rfSwallow(rfSwallow), .rfProg(rfProg), .rfPrescSel(rfPrescSel), .rfPhasePol(rfPhasePol),
    .monOut(monOut)
  );

  typedef struct packed {
    logic [13:0] ifR; logic ifCs;
    logic [13:0] rfR; logic rfCs;
    logic [6:0] ifA; logic [10:0] ifN; logic ifSw; logic ifFc;
    logic [6:0] rfA; logic [10:0] rfN; logic rfSw; logic rfFc;
  } exp_t;

  exp_t model = '0;
  logic [1:0] modelSel = 2'b0;
  logic modelMen = 1'b0;
  exp_t expQ[$];
  string tagQ[$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit positions 1..23 map to index 0..22
  function automatic logic [22:0] refWord(logic cn1, logic cn2, logic s0, logic s1,
                                          logic [13:0] r, logic cs, logic [3:0] dc);
    logic [22:0] w;
    w = {dc, cs, r, s1, s0, cn2, cn1};
    return w;
  endfunction

  function automatic logic [22:0] mainWord(logic cn1, logic cn2, logic men, logic [6:0] a,
                                           logic [10:0] n, logic sw, logic fc);
    return {fc, sw, n, a, men, cn2, cn1};
  endfunction

  function automatic void applyWord(logic [22:0] w);
    case ({w[1], w[0]})
      2'd0: if (w[17:4] >= 14'd3) begin model.ifR = w[17:4]; model.ifCs = w[18]; modelSel = {w[3], w[2]}; end
      2'd1: if (w[17:4] >= 14'd3) begin model.rfR = w[17:4]; model.rfCs = w[18]; end
      2'd2: begin model.ifA = w[9:3]; model.ifN = w[20:10]; model.ifSw = w[21]; model.ifFc = w[22]; modelMen = w[2]; end
      default: begin model.rfA = w[9:3]; model.rfN = w[20:10]; model.rfSw = w[21]; model.rfFc = w[22]; modelMen = w[2]; end
    endcase
  endfunction

  task automatic serialBit(logic b);
    @(negedge clk); serData = b; serClk = 1'b0;
    repeat (3) @(negedge clk);
    serClk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseLoad(logic [22:0] w, string tag, int junk);
    @(negedge clk); serClk = 1'b0;
    repeat (3) @(negedge clk);
    serLoad = 1'b1;
    applyWord(w);
    expQ.push_back(model);
    tagQ.push_back(tag);
    for (int j = 0; j < junk; j++) begin
      repeat (2) @(negedge clk); serData = 1'b1; serClk = 1'b1;
      repeat (2) @(negedge clk); serClk = 1'b0;
    end
    repeat (8) @(negedge clk);
    serLoad = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendWord(logic [22:0] w, string tag, int junk = 0);
    for (int i = 22; i >= 0; i--) serialBit(w[i]);
    pulseLoad(w, tag, junk);
  endtask

  task automatic checkMon(string tag);
    for (int s = 0; s < 4; s++) begin
      for (int lv = 0; lv < 2; lv++) begin
        @(negedge clk);
        taps = 4'(1 << s);
        lockIn = lv[0];
        if (lv == 1) taps = ~taps;
        #1;
        check(tag, 64'(monOut), 64'(modelMen ? taps[modelSel] : lockIn));
      end
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      exp_t e; string t;
      while (expQ.size() == 0) @(negedge clk);
      repeat (4) @(negedge clk);
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check({t, " IF ref (R2/R3)"}, 64'({ifRefRatio, ifRefPumpHi}), 64'({e.ifR, e.ifCs}));
      check({t, " RF ref (R2/R3)"}, 64'({rfRefRatio, rfRefPumpHi}), 64'({e.rfR, e.rfCs}));
      check({t, " IF main (R2/R4)"}, 64'({ifSwallow, ifProg, ifPrescSel, ifPhasePol}),
            64'({e.ifA, e.ifN, e.ifSw, e.ifFc}));
      check({t, " RF main (R2/R4)"}, 64'({rfSwallow, rfProg, rfPrescSel, rfPhasePol}),
            64'({e.rfA, e.rfN, e.rfSw, e.rfFc}));
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset latches", 64'({ifRefRatio, rfRefRatio, ifRefPumpHi, rfRefPumpHi, ifSwallow, ifProg,
          ifPrescSel, ifPhasePol, rfSwallow, rfProg, rfPrescSel, rfPhasePol}), 64'd0);
    checkMon("R10 R7 reset monitor");

    // R1 R3: IF reference, don't-care bits set
    sendWord(refWord(0, 0, 0, 0, 14'd100, 1'b1, 4'b1010), "R1 R3 IF ref 100");
    // RF reference at the top ratio
    sendWord(refWord(1, 0, 1, 1, 14'd16383, 1'b0, 4'b0101), "R3 RF ref max");
    // R4 IF main, enable 0
    sendWord(mainWord(0, 1, 0, 7'd127, 11'd3, 1'b1, 1'b0), "R4 IF main");
    checkMon("R7 monitor shows lock");
    // RF main, enable 1
    sendWord(mainWord(1, 1, 1, 7'd5, 11'd2047, 1'b0, 1'b1), "R4 RF main");
    checkMon("R8 R9 select 0");
    // R8: walk the IF reference select values
    sendWord(refWord(0, 0, 1, 0, 14'd3, 1'b0, 4'b1111), "R8 IF ref sel 1");
    checkMon("R8 select 1");
    sendWord(refWord(0, 0, 0, 1, 14'd4097, 1'b1, 4'b0000), "R8 IF ref sel 2");
    checkMon("R8 select 2");
    sendWord(refWord(0, 0, 1, 1, 14'd8191, 1'b0, 4'b0011), "R8 IF ref sel 3");
    checkMon("R8 select 3");
    // R9: IF main load clears enable, a later one sets it
    sendWord(mainWord(0, 1, 0, 7'd64, 11'd1000, 1'b0, 1'b1), "R9 IF main en 0");
    checkMon("R9 lock after IF main");
    sendWord(mainWord(0, 1, 1, 7'd1, 11'd513, 1'b1, 1'b1), "R9 IF main en 1");
    checkMon("R9 tap after IF main");
    // R6: prohibited ratios are discarded
    sendWord(refWord(0, 0, 0, 0, 14'd2, 1'b1, 4'b0000), "R6 IF ref 2 dropped");
    checkMon("R6 select kept");
    sendWord(refWord(1, 0, 0, 0, 14'd0, 1'b1, 4'b0000), "R6 RF ref 0 dropped");
    sendWord(refWord(1, 0, 0, 0, 14'd3, 1'b1, 4'b0000), "R6 RF ref 3 accepted");
    // R5: serial edges with load high are ignored, a reload copies the same word
    sendWord(mainWord(1, 1, 0, 7'd42, 11'd1365, 1'b1, 1'b0), "R5 RF main", 3);
    pulseLoad(mainWord(1, 1, 0, 7'd42, 11'd1365, 1'b1, 1'b0), "R5 reload", 0);
    checkMon("R5 monitor after reload");

    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule